// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock sent to an SD or MMC card from the kernel clock. A single control word sets how the clock is produced. That word holds a 10-bit divider, a launch-edge select, a power-save enable, a flow-control enable and two bus-width bits. With a nonzero divider N, the card clock runs at the kernel rate divided by 2N. It is high for N kernel cycles and then low for N kernel cycles. With a zero divider the kernel clock passes straight through, gated cleanly. Alongside the clock the block raises a one-kernel-cycle strobe. The strobe marks the card clock edge at which the command and data drivers may change their outputs. The block also reports the decoded bus width to the data path.

The clock can be parked low in two cases. The first is when power-save is enabled and the bus reports idle. The second is when flow control is enabled and the data path asks for a hold. Parking happens only after a complete low phase, so the card never sees a clipped pulse.

A state machine with four states drives the clock. PH_PARK holds the clock low and is the reset state. PH_HIGH and PH_LOW are the two divided half-periods, and each one counts N kernel cycles. PH_BYPASS lets the kernel clock through. The transitions are:
- PH_PARK goes to PH_BYPASS when the hold condition is gone and the divider is zero.
- PH_PARK goes to PH_HIGH when the hold condition is gone and the divider is nonzero.
- PH_HIGH goes to PH_LOW after N cycles.
- PH_LOW goes to PH_PARK after N cycles when the hold condition is present.
- PH_LOW goes to PH_BYPASS after N cycles when the divider is zero.
- PH_LOW goes to PH_HIGH after N cycles otherwise.
- PH_BYPASS goes to PH_LOW when a nonzero divider is written.
- PH_BYPASS goes to PH_PARK when the hold condition appears.

The divider in force is loaded on every entry to PH_HIGH, and also on the move from PH_BYPASS to PH_LOW.

Top module: `sdclk_gen`

## Requirements
- R1: For a nonzero divider N, every card clock high phase and every low phase lasts exactly N kernel cycles.
- R2: The divider occupies control bits 9:0, so its largest value is 1023. Control bits 10, 11, 13 and 18 to 31 have no effect on the clock.
- R3: With a zero divider, the card clock is high in the high phase and low in the low phase of every kernel cycle. The strobe is high every cycle, whatever the edge-select value (bit 16).
- R4: With a nonzero divider, the strobe is high for exactly one kernel cycle per card period. If bit 16 is 0, that cycle is the first high cycle. If bit 16 is 1, it is the first low cycle.
- R5: With power-save (bit 12) set and bus_idle high, the card clock stays low and the strobe stays low once the current low phase ends. When bus_idle drops, the clock resumes with a full-length high phase. With bit 12 clear, bus_idle has no effect.
- R6: With flow control (bit 17) set and dp_hold high, the clock parks in the same way as in R5. With bit 17 clear, dp_hold has no effect.
- R7: A new divider written mid-period does not alter the current period. The high phase in progress and the low phase that follows keep the old length, and the next high phase uses the new value.
- R8: bus_width is 2'b00 for a 1-bit bus when bits 14 and 15 are both clear. It is 2'b01 for a 4-bit bus when only bit 14 is set. It is 2'b10 for an 8-bit bus when bit 15 is set, whether or not bit 14 is set. The value is visible from the cycle after the write.
- R9: While reset is asserted, card_clk, launch_stb and bus_width are all 0. After release, the zero divider puts the clock in pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ker | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control word write enable |
| cfg_wr_data | input | REG_W | Control word |
| bus_idle | input | 1 | Bus idle, parks the clock under power-save |
| dp_hold | input | 1 | Data path cannot move data, parks the clock under flow control |
| card_clk | output | 1 | Clock to the card |
| launch_stb | output | 1 | One kernel cycle per launching card edge |
| bus_width | output | 2 | Decoded bus width: 00 one bit, 01 four bits, 10 eight bits |

## Verification
A half-period counter or stored divider that is off by one shows as a high or low run of the wrong length. That error appears within the first card period after the divider is loaded, which is at most 2N kernel cycles. A wrong state transition shows as a strobe in the wrong cycle or a missing strobe at the very next card edge. It can also show as a clock that fails to park or fails to resume within one low phase. A broken pass-through gate shows within one kernel cycle as a missing or stretched pulse. The sweeps cover every divider from 1 to 8 in both edge modes, together with the maximum divider.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    // Control word bit positions.
    localparam int PSAVE_BIT = 12;
    localparam int W4_BIT    = 14;
    localparam int W8_BIT    = 15;
    localparam int EDGE_BIT  = 16;
    localparam int FLOW_BIT  = 17;

    typedef enum logic [1:0] {
        PH_PARK   = 2'd0,
        PH_HIGH   = 2'd1,
        PH_LOW    = 2'd2,
        PH_BYPASS = 2'd3
    } ph_t;

    typedef enum logic [1:0] {
        BW_1 = 2'b00,
        BW_4 = 2'b01,
        BW_8 = 2'b10
    } bw_t;

    typedef struct packed {
        logic flow_en;
        logic edge_fall;
        logic psave;
        bw_t  width;
    } cfg_t;

endpackage

// File: rtl/sdclk_cfg.sv
module sdclk_cfg #(
    parameter int REG_W = 32,
    parameter int DIV_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [DIV_W-1:0]     div_cfg,
    output sdclk_pkg::cfg_t      cfg
);
    import sdclk_pkg::*;

    localparam int TOP_USED = FLOW_BIT;

    bw_t  width_dec;
    logic unused_bits;

    // An 8-bit request wins over a 4-bit request.
    always_comb begin
        if (wr_data[W8_BIT])
            width_dec = BW_8;
        else if (wr_data[W4_BIT])
            width_dec = BW_4;
        else
            width_dec = BW_1;
    end

    assign unused_bits = ^{wr_data[REG_W-1:TOP_USED+1], wr_data[13], wr_data[11:DIV_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cfg <= '0;
            cfg     <= '0;
        end else if (wr_en) begin
            div_cfg       <= wr_data[DIV_W-1:0];
            cfg.flow_en   <= wr_data[FLOW_BIT];
            cfg.edge_fall <= wr_data[EDGE_BIT];
            cfg.psave     <= wr_data[PSAVE_BIT];
            cfg.width     <= width_dec;
        end
    end

endmodule

// File: rtl/sdclk_fsm.sv
module sdclk_fsm #(
    parameter int DIV_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              edge_fall,
    input  logic              hold,
    output logic              div_clk,
    output logic              stb,
    output logic              byp_run,
    output sdclk_pkg::ph_t    state,
    output logic [DIV_W-1:0]  div_act
);
    import sdclk_pkg::*;

    ph_t              nxt;
    logic [DIV_W-1:0] cnt;
    logic             phase_end;
    logic             div_zero;
    logic             load;
    logic             stb_nxt;

    assign div_zero  = (div_cfg == '0);
    assign phase_end = (({1'b0, cnt} + 1'b1) == {1'b0, div_act});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PH_PARK;
        else
            state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            PH_PARK: begin
                if (!hold)
                    nxt = div_zero ? PH_BYPASS : PH_HIGH;
            end
            PH_HIGH: begin
                if (phase_end)
                    nxt = PH_LOW;
            end
            PH_LOW: begin
                if (phase_end) begin
                    if (hold)
                        nxt = PH_PARK;
                    else if (div_zero)
                        nxt = PH_BYPASS;
                    else
                        nxt = PH_HIGH;
                end
            end
            PH_BYPASS: begin
                if (!div_zero)
                    nxt = PH_LOW;
                else if (hold)
                    nxt = PH_PARK;
            end
        endcase
    end

    // A new divider is taken only at a period boundary.
    assign load = ((nxt == PH_HIGH) && (state != PH_HIGH)) ||
                  ((nxt == PH_LOW)  && (state == PH_BYPASS));

    assign stb_nxt = (state == PH_BYPASS) ||
                     ((nxt == PH_HIGH) && (state != PH_HIGH) && !edge_fall) ||
                     ((nxt == PH_LOW)  && (state == PH_HIGH) &&  edge_fall);

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            div_act <= '0;
            div_clk <= 1'b0;
            stb     <= 1'b0;
        end else begin
            if ((nxt == state) && ((state == PH_HIGH) || (state == PH_LOW)))
                cnt <= cnt + 1'b1;
            else
                cnt <= '0;
            if (load)
                div_act <= div_cfg;
            div_clk <= (nxt == PH_HIGH);
            stb     <= stb_nxt;
        end
    end

    assign byp_run = (state == PH_BYPASS);

endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic byp_run,
    input  logic div_clk,
    output logic card_clk
);
    logic gate_q;

    // Enable changes only while the kernel clock is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else
            gate_q <= byp_run;
    end

    // div_clk and gate_q are never high in the same kernel cycle.
    assign card_clk = (clk & gate_q) | div_clk;

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
    parameter int REG_W = 32,
    parameter int DIV_W = 10
) (
    input  logic             clk_ker,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wr_data,
    input  logic             bus_idle,
    input  logic             dp_hold,
    output logic             card_clk,
    output logic             launch_stb,
    output logic [1:0]       bus_width
);
    import sdclk_pkg::*;

    cfg_t             cfg_q;
    logic [DIV_W-1:0] div_cfg;
    logic [DIV_W-1:0] div_act;
    logic             hold_req;
    logic             div_clk_w;
    logic             byp_run;
    ph_t              ph_w;

    sdclk_cfg #(.REG_W(REG_W), .DIV_W(DIV_W)) u_cfg (
        .clk     (clk_ker),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .div_cfg (div_cfg),
        .cfg     (cfg_q)
    );

    assign hold_req = (cfg_q.psave & bus_idle) | (cfg_q.flow_en & dp_hold);

    sdclk_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk       (clk_ker),
        .rst_n     (rst_n),
        .div_cfg   (div_cfg),
        .edge_fall (cfg_q.edge_fall),
        .hold      (hold_req),
        .div_clk   (div_clk_w),
        .stb       (launch_stb),
        .byp_run   (byp_run),
        .state     (ph_w),
        .div_act   (div_act)
    );

    sdclk_gate u_gate (
        .clk      (clk_ker),
        .rst_n    (rst_n),
        .byp_run  (byp_run),
        .div_clk  (div_clk_w),
        .card_clk (card_clk)
    );

    assign bus_width = cfg_q.width;

endmodule

// File: rtl/sdclk_chk.sv
module sdclk_chk #(
    parameter int DIV_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_w8,
    input logic [1:0]       bus_width,
    input logic             stb,
    input logic             div_clk,
    input sdclk_pkg::ph_t   state,
    input logic [DIV_W-1:0] div_act,
    input logic             edge_fall,
    input logic             hold
);
    import sdclk_pkg::*;

    logic [DIV_W:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= '0;
        else
            hi_cnt <= div_clk ? hi_cnt + 1'b1 : '0;
    end

    assert_high_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_clk) |-> (hi_cnt == {1'b0, div_act}));

    assert_bypass_stb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_BYPASS) |=> stb);

    assert_rise_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(div_clk) && !$past(edge_fall)) |-> stb);

    assert_fall_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(div_clk) && $past(edge_fall)) |-> stb);

    // Covers both park sources (R5 and R6).
    assert_no_rise_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_clk) |-> !$past(hold));

    assert_width_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_width != 2'b11);

    assert_width8_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_w8) |=> (bus_width == BW_8));

endmodule

bind sdclk_gen sdclk_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk_ker),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_w8     (cfg_wr_data[sdclk_pkg::W8_BIT]),
    .bus_width (bus_width),
    .stb       (launch_stb),
    .div_clk   (div_clk_w),
    .state     (ph_w),
    .div_act   (div_act),
    .edge_fall (cfg_q.edge_fall),
    .hold      (hold_req)
);

// File: tb/sim_sdclk_gen.sv
`timescale 1ns/1ps
module sim_sdclk_gen;
    localparam int REG_W = 32;
    localparam int DIV_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic             bus_idle = 1'b0;
    logic             dp_hold = 1'b0;
    logic             card_clk;
    logic             launch_stb;
    logic [1:0]       bus_width;

    int   n_chk = 0;
    int   n_fail = 0;
    logic ck = 1'b0;
    logic sb = 1'b0;
    logic pck = 1'b0;
    logic rise = 1'b0;

    always #4 clk = ~clk;

    sdclk_gen #(.REG_W(REG_W), .DIV_W(DIV_W)) u0 (
        .clk_ker     (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (wr_en),
        .cfg_wr_data (wr_data),
        .bus_idle    (bus_idle),
        .dp_hold     (dp_hold),
        .card_clk    (card_clk),
        .launch_stb  (launch_stb),
        .bus_width   (bus_width)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample 2 ns after the rising edge, in the high phase of the kernel clock.
    task automatic cyc();
        @(posedge clk);
        #2;
        pck  = ck;
        ck   = card_clk;
        sb   = launch_stb;
        rise = ck && !pck;
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        cyc();
    endtask

    function automatic logic [31:0] mk(input int dv, input bit ef, input bit ps,
                                       input bit w4, input bit w8, input bit fl);
        logic [31:0] w;
        w = 32'(dv) & 32'h3FF;
        w[16] = ef;
        w[12] = ps;
        w[14] = w4;
        w[15] = w8;
        w[17] = fl;
        return w;
    endfunction

    task automatic wait_rise();
        int g;
        g = 0;
        cyc();
        while (!rise && g < 6000) begin
            cyc();
            g++;
        end
        if (!rise) check(1'b0, "R1 card clock edge missing", 0, 1);
    endtask

    // Entered on the first high sample; leaves on the next first high sample.
    task automatic meas(output int h, output int l, output int sc, output int sp);
        int idx;
        idx = 0; h = 0; l = 0; sc = 0; sp = -1;
        while (ck && h < 3000) begin
            if (sb) begin sc++; sp = idx; end
            h++; idx++;
            cyc();
        end
        while (!ck && l < 3000) begin
            if (sb) begin sc++; sp = idx; end
            l++; idx++;
            cyc();
        end
    endtask

    task automatic check_div(input logic [31:0] w, input int n, input bit ef, input string req);
        int h, l, sc, sp;
        wr(w);
        wait_rise();
        wait_rise();
        meas(h, l, sc, sp);
        check(h == n, {req, " high phase length"}, h, n);
        check(l == n, {req, " low phase length"}, l, n);
        check(sc == 1, "R4 strobes per period", sc, 1);
        check(sp == (ef ? n : 0), "R4 strobe position", sp, ef ? n : 0);
    endtask

    task automatic count_rises(input int len, output int r);
        r = 0;
        repeat (len) begin
            cyc();
            if (rise) r++;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int h, l, sc, sp, r, bad;

        // R9: reset state
        repeat (3) @(posedge clk);
        #2;
        check(card_clk == 1'b0, "R9 card_clk in reset (high phase)", card_clk, 0);
        check(launch_stb == 1'b0, "R9 launch_stb in reset", launch_stb, 0);
        check(bus_width == 2'b00, "R9 bus_width in reset", bus_width, 0);
        @(negedge clk);
        #2;
        check(card_clk == 1'b0, "R9 card_clk in reset (low phase)", card_clk, 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        repeat (4) cyc();
        check(ck == 1'b1 && sb == 1'b1, "R9 pass-through after reset", ck, 1);

        // R8: bus width decode
        wr(mk(0, 0, 0, 0, 0, 0));
        check(bus_width == 2'b00, "R8 one-bit width", bus_width, 0);
        wr(mk(0, 0, 0, 1, 0, 0));
        check(bus_width == 2'b01, "R8 four-bit width", bus_width, 1);
        wr(mk(0, 0, 0, 0, 1, 0));
        check(bus_width == 2'b10, "R8 eight-bit width", bus_width, 2);
        wr(mk(0, 0, 0, 1, 1, 0));
        check(bus_width == 2'b10, "R8 both bits give eight-bit", bus_width, 2);

        // R3: pass-through, both edge-select values
        for (int ef = 0; ef < 2; ef++) begin
            wr(mk(0, ef[0], 0, 0, 0, 0));
            repeat (10) cyc();
            bad = 0;
            for (int k = 0; k < 6; k++) begin
                cyc();
                if (!(ck && sb)) bad++;
                @(negedge clk);
                #2;
                if (card_clk) bad++;
            end
            check(bad == 0, "R3 pass-through pulses and strobe", bad, 0);
        end

        // R1, R4: sweep of small dividers in both edge modes
        for (int n = 1; n <= 8; n++) begin
            for (int ef = 0; ef < 2; ef++) begin
                check_div(mk(n, ef[0], 0, 0, 0, 0), n, ef[0], "R1");
            end
        end

        // R2: bits outside the fields are ignored
        check_div(mk(5, 0, 1, 1, 0, 0) | 32'hFFFC_2C00, 5, 1'b0, "R2");

        // R7: divider change in the middle of a high phase
        check_div(mk(4, 0, 0, 0, 0, 0), 4, 1'b0, "R1");
        h = 1;
        cyc();
        if (ck) h++;
        wr(mk(2, 0, 0, 0, 0, 0));
        if (ck) h++;
        while (ck && h < 20) begin
            cyc();
            if (ck) h++;
        end
        l = 0;
        while (!ck && l < 20) begin
            l++;
            cyc();
        end
        check(h == 4, "R7 current high keeps old length", h, 4);
        check(l == 4, "R7 following low keeps old length", l, 4);
        meas(h, l, sc, sp);
        check(h == 2, "R7 new high length", h, 2);
        check(l == 2, "R7 new low length", l, 2);

        // R5: power-save parks the divided clock
        wr(mk(3, 0, 1, 0, 0, 0));
        bus_idle = 1'b1;
        repeat (20) cyc();
        bad = 0;
        repeat (20) begin
            cyc();
            if (ck || sb) bad++;
        end
        check(bad == 0, "R5 clock parked while idle", bad, 0);
        bus_idle = 1'b0;
        wait_rise();
        meas(h, l, sc, sp);
        check(h == 3, "R5 full high after resume", h, 3);
        check(l == 3, "R5 full low after resume", l, 3);

        // R5: bus_idle has no effect with power-save clear
        wr(mk(3, 0, 0, 0, 0, 0));
        bus_idle = 1'b1;
        count_rises(36, r);
        check(r >= 5, "R5 idle ignored without power-save", r, 6);
        bus_idle = 1'b0;

        // R5: power-save parks the pass-through clock
        wr(mk(0, 0, 1, 0, 0, 0));
        repeat (12) cyc();
        bus_idle = 1'b1;
        repeat (10) cyc();
        bad = 0;
        repeat (5) begin
            cyc();
            if (ck || sb) bad++;
        end
        check(bad == 0, "R5 pass-through parked", bad, 0);
        bus_idle = 1'b0;
        repeat (5) cyc();
        check(ck == 1'b1, "R5 pass-through resumes", ck, 1);

        // R6: flow control parks and releases
        wr(mk(2, 0, 0, 0, 0, 1));
        repeat (10) cyc();
        dp_hold = 1'b1;
        repeat (10) cyc();
        bad = 0;
        repeat (15) begin
            cyc();
            if (ck || sb) bad++;
        end
        check(bad == 0, "R6 clock parked on hold", bad, 0);
        dp_hold = 1'b0;
        wait_rise();
        meas(h, l, sc, sp);
        check(h == 2 && l == 2, "R6 full period after release", h + l, 4);

        // R6: dp_hold has no effect with flow control clear
        wr(mk(3, 0, 0, 0, 0, 0));
        dp_hold = 1'b1;
        count_rises(36, r);
        check(r >= 5, "R6 hold ignored without flow control", r, 6);
        dp_hold = 1'b0;

        // R2: largest divider
        check_div(32'h0000_03FF, 1023, 1'b0, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule